// File: doc/BRIEF.md
# SDRAM Full-Page Burst Read Sequencer

This block drives one SDR SDRAM device through a single full-page burst read on behalf of a host. The host presents a bank, a row, a start column and a word count, then pulses a start strobe. The block opens the row, waits the row-to-column delay, and issues the read. It then streams the returned words to the host with a valid strobe. A full-page burst never ends by itself and wraps around inside the open row, so the block ends it with a burst-terminate command. It times that command so that exactly the requested number of words arrives, counting the words still in flight behind the CAS latency.

The row is left open when the operation completes, and no precharge is issued. The device data width (x4, x8 or x16) is a parameter. It sets the column width and the address pins that carry the column. The CAS latency (2 or 3) and the row-to-column delay in whole clocks are also parameters.

Top module: `fpb_read_seq`

## Requirements
- R1: A start pulse seen in an idle cycle with a nonzero length is accepted at that clock edge. In the next cycle the command pins {cs_n,ras_n,cas_n,we_n} carry ACTIVE (4'b0011), with the requested row on the address pins and the requested bank on the bank pins.
- R2: READ (4'b0101) appears exactly RCD_CYC cycles after ACTIVE, to the same bank, with address bit 10 low so that no auto-precharge is selected. Only NOP (4'b0111) appears in between.
- R3: On READ the column sits on the address pins as the data width requires: x16 uses bits 8..0; x8 uses bits 9..0; x4 uses bits 9..0 plus bit 11 for column bit 10. Every other address bit is zero.
- R4: For a length N, exactly one BURST TERMINATE (4'b0110) is issued, N cycles after READ. All other commands while the block is busy are NOP.
- R5: Exactly N words are delivered on rd_data with rd_valid high. Word k is the value on the data pins CAS_LAT+k cycles after READ, and it is presented one cycle later. The first rd_valid therefore comes CAS_LAT+1 cycles after READ.
- R6: The CAS_LAT-1 words that arrive after BURST TERMINATE are still captured. The last rd_valid falls CAS_LAT cycles after BURST TERMINATE.
- R7: The block issues only ACTIVE, READ, BURST TERMINATE and NOP. No precharge is ever issued, and the command is NOP whenever the block is idle.
- R8: A start pulse while busy is ignored: no second ACTIVE, and the running burst keeps its arguments.
- R9: A start pulse with length zero is ignored, and busy stays low.
- R10: busy is high from the cycle of ACTIVE until done. done is a one-cycle pulse, CAS_LAT+1 cycles after BURST TERMINATE, and busy is low in the following cycle.
- R11: Clock enable is high from the first cycle after reset. DQM is low in every busy cycle and high when idle. After reset the block is idle, with NOP on the command pins and done and rd_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Start strobe for one burst read |
| req_bank | input | BANK_W | Bank to read |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | First column of the burst |
| req_len | input | LEN_W | Number of words to deliver |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DEV_WIDTH | Captured word |
| rd_valid | output | 1 | rd_data holds a new word |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_ba | output | BANK_W | SDRAM bank address |
| sd_addr | output | ADDR_W | SDRAM address pins |
| sd_dqm | output | DQM_W | SDRAM data mask |
| sd_dq | input | DEV_WIDTH | SDRAM data pins (read only here) |

## Verification
The assertions assume that the host keeps its arguments stable only at the accepting edge, and that the SDRAM answers a READ with data exactly CAS_LAT cycles later. They count cycles from ACTIVE and from READ against the length latched at acceptance, so they rely on a start pulse being taken only when busy is low. The stimulus drives every request on the falling edge and holds start for one cycle. A behavioural memory drives the data pins with a column-dependent pattern that wraps at the end of the page. Extra start pulses are injected only while a burst is running, to exercise the ignore path.

// File: rtl/fpb_pkg.sv
`timescale 1ns/1ps
package fpb_pkg;

   // SDRAM command encoding on {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] SDC_NOP = 4'b0111;
   localparam logic [3:0] SDC_ACT = 4'b0011;
   localparam logic [3:0] SDC_RD  = 4'b0101;
   localparam logic [3:0] SDC_BT  = 4'b0110;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_ACT,
      SQ_WAIT,
      SQ_RD,
      SQ_STRM,
      SQ_TERM,
      SQ_DRAIN,
      SQ_FIN
   } seq_state_t;

   // column address width for a given device data width
   function automatic int col_bits(input int dev_w);
      case (dev_w)
         4:       col_bits = 11;
         8:       col_bits = 10;
         default: col_bits = 9;
      endcase
   endfunction

endpackage

// File: rtl/fpb_wait_cnt.sv
`timescale 1ns/1ps
module fpb_wait_cnt #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/fpb_col_map.sv
`timescale 1ns/1ps
module fpb_col_map #(
   parameter int DEV_WIDTH = 16,
   parameter int COL_W     = 9,
   parameter int ADDR_W    = 13
) (
   input  logic [COL_W-1:0]  col,
   output logic [ADDR_W-1:0] addr
);

   generate
      if (DEV_WIDTH == 4) begin : g_x4
         always_comb begin
            addr     = '0;
            addr[9:0] = col[9:0];
            addr[11] = col[10];
         end
      end else if (DEV_WIDTH == 8) begin : g_x8
         always_comb begin
            addr      = '0;
            addr[9:0] = col;
         end
      end else begin : g_x16
         always_comb begin
            addr      = '0;
            addr[8:0] = col;
         end
      end
   endgenerate

endmodule

// File: rtl/fpb_capture.sv
`timescale 1ns/1ps
module fpb_capture #(
   parameter int DQ_W    = 16,
   parameter int CAS_LAT = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            slot_req,
   input  logic [DQ_W-1:0] dq,
   output logic [DQ_W-1:0] word,
   output logic            word_vld,
   output logic            pending
);

   // stage i holds the slot request issued i+1 cycles ago
   logic [CAS_LAT-1:0] slot_q;

   generate
      for (genvar gi = 0; gi < CAS_LAT; gi++) begin : g_stage
         if (gi == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) slot_q[0] <= 1'b0;
               else        slot_q[0] <= slot_req;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (!rst_n) slot_q[gi] <= 1'b0;
               else        slot_q[gi] <= slot_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word     <= '0;
         word_vld <= 1'b0;
      end else begin
         word_vld <= slot_q[CAS_LAT-1];
         if (slot_q[CAS_LAT-1]) word <= dq;
      end
   end

   assign pending = |slot_q;

endmodule

// File: rtl/fpb_read_seq.sv
`timescale 1ns/1ps
module fpb_read_seq
   import fpb_pkg::*;
#(
   parameter int DEV_WIDTH = 16,
   parameter int CAS_LAT   = 2,
   parameter int RCD_CYC   = 2,
   parameter int BANK_W    = 2,
   parameter int ROW_W     = 13,
   parameter int ADDR_W    = 13,
   parameter int COL_W     = col_bits(DEV_WIDTH),
   parameter int LEN_W     = COL_W + 1,
   parameter int DQM_W     = (DEV_WIDTH == 16) ? 2 : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_start,
   input  logic [BANK_W-1:0]    req_bank,
   input  logic [ROW_W-1:0]     req_row,
   input  logic [COL_W-1:0]     req_col,
   input  logic [LEN_W-1:0]     req_len,
   output logic                 busy,
   output logic                 done,
   output logic [DEV_WIDTH-1:0] rd_data,
   output logic                 rd_valid,
   output logic                 sd_cke,
   output logic                 sd_cs_n,
   output logic                 sd_ras_n,
   output logic                 sd_cas_n,
   output logic                 sd_we_n,
   output logic [BANK_W-1:0]    sd_ba,
   output logic [ADDR_W-1:0]    sd_addr,
   output logic [DQM_W-1:0]     sd_dqm,
   input  logic [DEV_WIDTH-1:0] sd_dq
);

   localparam int RCD_W = (RCD_CYC < 2) ? 1 : $clog2(RCD_CYC + 1);

   // elaboration-time parameter checks
   generate
      if (!(DEV_WIDTH == 4 || DEV_WIDTH == 8 || DEV_WIDTH == 16)) begin : g_bad_w
         $error("fpb_read_seq: DEV_WIDTH must be 4, 8 or 16");
      end
      if (!(CAS_LAT == 2 || CAS_LAT == 3)) begin : g_bad_cl
         $error("fpb_read_seq: CAS_LAT must be 2 or 3");
      end
      if (RCD_CYC < 1) begin : g_bad_rcd
         $error("fpb_read_seq: RCD_CYC must be at least 1");
      end
      if (ROW_W > ADDR_W || ADDR_W < 12) begin : g_bad_addr
         $error("fpb_read_seq: address width too small");
      end
      if (COL_W != col_bits(DEV_WIDTH)) begin : g_bad_col
         $error("fpb_read_seq: COL_W does not match DEV_WIDTH");
      end
   endgenerate

   seq_state_t          state_q, state_d;
   logic [BANK_W-1:0]   bank_q;
   logic [ROW_W-1:0]    row_q;
   logic [COL_W-1:0]    col_q;
   logic [LEN_W-1:0]    len_q;
   logic [LEN_W-1:0]    cnt_q;
   logic                cke_q;
   logic                accept;
   logic                slot_req;
   logic                rcd_last;
   logic                cap_pending;
   logic [ADDR_W-1:0]   col_addr;
   logic [3:0]          cmd;

   assign accept = (state_q == SQ_IDLE) && req_start && (req_len != '0);

   // ---------------- request latch and state register ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         bank_q  <= '0;
         row_q   <= '0;
         col_q   <= '0;
         len_q   <= '0;
         cnt_q   <= '0;
         cke_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         cke_q   <= 1'b1;
         if (accept) begin
            bank_q <= req_bank;
            row_q  <= req_row;
            col_q  <= req_col;
            len_q  <= req_len;
         end
         if (state_q == SQ_RD)        cnt_q <= LEN_W'(1);
         else if (state_q == SQ_STRM) cnt_q <= cnt_q + LEN_W'(1);
      end
   end

   // ---------------- next state ----------------
   always_comb begin
      state_d  = state_q;
      slot_req = 1'b0;
      case (state_q)
         SQ_IDLE:  if (accept) state_d = SQ_ACT;
         SQ_ACT:   state_d = (RCD_CYC == 1) ? SQ_RD : SQ_WAIT;
         SQ_WAIT:  if (rcd_last) state_d = SQ_RD;
         SQ_RD: begin
            slot_req = 1'b1;
            state_d  = (len_q == LEN_W'(1)) ? SQ_TERM : SQ_STRM;
         end
         SQ_STRM: begin
            slot_req = 1'b1;
            if (cnt_q == len_q - LEN_W'(1)) state_d = SQ_TERM;
         end
         SQ_TERM:  state_d = SQ_DRAIN;
         SQ_DRAIN: if (!cap_pending) state_d = SQ_FIN;
         SQ_FIN:   state_d = SQ_IDLE;
         default:  state_d = SQ_IDLE;
      endcase
   end

   // ---------------- sub-blocks ----------------
   fpb_wait_cnt #(
      .CNT_W (RCD_W)
   ) u_rcd (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (state_q == SQ_ACT),
      .load_val (RCD_W'(RCD_CYC - 1)),
      .last     (rcd_last)
   );

   fpb_col_map #(
      .DEV_WIDTH (DEV_WIDTH),
      .COL_W     (COL_W),
      .ADDR_W    (ADDR_W)
   ) u_colmap (
      .col  (col_q),
      .addr (col_addr)
   );

   fpb_capture #(
      .DQ_W    (DEV_WIDTH),
      .CAS_LAT (CAS_LAT)
   ) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot_req (slot_req),
      .dq       (sd_dq),
      .word     (rd_data),
      .word_vld (rd_valid),
      .pending  (cap_pending)
   );

   // ---------------- pin decode ----------------
   always_comb begin
      cmd     = SDC_NOP;
      sd_addr = '0;
      case (state_q)
         SQ_ACT: begin
            cmd     = SDC_ACT;
            sd_addr = ADDR_W'(row_q);
         end
         SQ_RD: begin
            cmd     = SDC_RD;
            sd_addr = col_addr;
         end
         SQ_TERM: cmd = SDC_BT;
         default: cmd = SDC_NOP;
      endcase
   end

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
   assign sd_ba  = bank_q;
   assign sd_cke = cke_q;
   assign busy   = (state_q != SQ_IDLE);
   assign done   = (state_q == SQ_FIN);
   assign sd_dqm = (state_q == SQ_IDLE) ? {DQM_W{1'b1}} : {DQM_W{1'b0}};

endmodule

// File: rtl/fpb_read_seq_chk.sv
`timescale 1ns/1ps
module fpb_read_seq_chk
   import fpb_pkg::*;
#(
   parameter int RCD_CYC = 2,
   parameter int ADDR_W  = 13,
   parameter int LEN_W   = 10,
   parameter int DQM_W   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_start,
   input logic [LEN_W-1:0]  req_len,
   input logic              busy,
   input logic              done,
   input logic              rd_valid,
   input logic              sd_cke,
   input logic              sd_cs_n,
   input logic              sd_ras_n,
   input logic              sd_cas_n,
   input logic              sd_we_n,
   input logic [ADDR_W-1:0] sd_addr,
   input logic [DQM_W-1:0]  sd_dqm
);

   logic [3:0]  cmd;
   logic [15:0] since_act;
   logic [15:0] since_rd;
   logic [LEN_W-1:0] len_seen;

   assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_act <= '0;
         since_rd  <= '0;
         len_seen  <= '0;
      end else begin
         if (cmd == SDC_ACT)          since_act <= 16'd1;
         else if (since_act != '1)    since_act <= since_act + 16'd1;
         if (cmd == SDC_RD)           since_rd <= 16'd1;
         else if (since_rd != '1)     since_rd <= since_rd + 16'd1;
         if (!busy && req_start && req_len != '0) len_seen <= req_len;
      end
   end

   assert_rcd_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == SDC_RD) |-> (since_act == 16'(RCD_CYC)));

   assert_no_autopre_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == SDC_RD) |-> !sd_addr[10]);

   assert_term_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == SDC_BT) |-> (since_rd == 16'(len_seen)));

   assert_valid_in_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> busy);

   assert_legal_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == SDC_NOP) || (cmd == SDC_ACT) || (cmd == SDC_RD) || (cmd == SDC_BT));

   assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_start) |=> (cmd != SDC_ACT));

   assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_start && req_len == '0) |=> !busy);

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   assert_pins_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (sd_cke && sd_dqm == '0));

endmodule

bind fpb_read_seq fpb_read_seq_chk #(
   .RCD_CYC (RCD_CYC),
   .ADDR_W  (ADDR_W),
   .LEN_W   (LEN_W),
   .DQM_W   (DQM_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_start (req_start),
   .req_len   (req_len),
   .busy      (busy),
   .done      (done),
   .rd_valid  (rd_valid),
   .sd_cke    (sd_cke),
   .sd_cs_n   (sd_cs_n),
   .sd_ras_n  (sd_ras_n),
   .sd_cas_n  (sd_cas_n),
   .sd_we_n   (sd_we_n),
   .sd_addr   (sd_addr),
   .sd_dqm    (sd_dqm)
);

// File: tb/fpb_read_seq_tb.sv
`timescale 1ns/1ps
module fpb_read_seq_tb;

   localparam int CL   = 2;
   localparam int RCD  = 2;
   localparam int PAGE = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_start = 1'b0;
   logic [1:0]  req_bank = '0;
   logic [12:0] req_row = '0;
   logic [8:0]  req_col = '0;
   logic [9:0]  req_len = '0;
   logic        busy, done, rd_valid;
   logic [15:0] rd_data;
   logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [1:0]  sd_ba;
   logic [12:0] sd_addr;
   logic [1:0]  sd_dqm;
   logic [15:0] sd_dq;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   fpb_read_seq #(
      .DEV_WIDTH (16),
      .CAS_LAT   (CL),
      .RCD_CYC   (RCD)
   ) u_dut (
      .clk (clk), .rst_n (rst_n),
      .req_start (req_start), .req_bank (req_bank), .req_row (req_row),
      .req_col (req_col), .req_len (req_len),
      .busy (busy), .done (done), .rd_data (rd_data), .rd_valid (rd_valid),
      .sd_cke (sd_cke), .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n),
      .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n), .sd_ba (sd_ba),
      .sd_addr (sd_addr), .sd_dqm (sd_dqm), .sd_dq (sd_dq)
   );

   function automatic logic [15:0] word_of(input logic [1:0] b, input logic [12:0] r,
                                           input logic [8:0] c);
      return {b, r[4:0], c};
   endfunction

   // ---------------- behavioural SDRAM ----------------
   logic [3:0]  cmd;
   logic [1:0]  m_bank;
   logic [12:0] m_row;
   logic [8:0]  m_col;
   logic        m_act;
   logic [CL-1:0] m_v;
   logic [15:0] m_d [CL];
   assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
   assign sd_dq = m_v[CL-1] ? m_d[CL-1] : 16'h0000;

   always @(posedge clk) begin
      logic       an;
      logic [8:0] cn;
      if (!rst_n) begin
         m_act <= 1'b0; m_v <= '0; m_col <= '0; m_bank <= '0; m_row <= '0;
      end else begin
         an = (cmd == 4'b0101) || (m_act && cmd != 4'b0110);
         cn = (cmd == 4'b0101) ? sd_addr[8:0] : m_col;
         if (cmd == 4'b0011) begin m_bank <= sd_ba; m_row <= sd_addr; end
         m_v <= {m_v[CL-2:0], an};
         for (int i = CL - 1; i > 0; i--) m_d[i] <= m_d[i-1];
         m_d[0] <= word_of(m_bank, m_row, cn);
         m_col <= cn + 9'd1;
         m_act <= an;
      end
   end

   // ---------------- monitor ----------------
   int cyc = 0;
   int act_n, rd_n, bt_n, other_n, idle_bad, cke_bad, dqm_bad, done_n;
   int act_cyc, rd_cyc, bt_cyc, done_cyc, first_v, last_v, word_n, mism;
   logic [12:0] act_row, rd_addr;
   logic [1:0]  act_ba, rd_ba;
   logic [1:0]  t_bank;
   logic [12:0] t_row;
   logic [8:0]  t_col;

   task automatic clear_mon();
      act_n = 0; rd_n = 0; bt_n = 0; other_n = 0; idle_bad = 0; cke_bad = 0;
      dqm_bad = 0; done_n = 0; act_cyc = -1; rd_cyc = -1; bt_cyc = -1;
      done_cyc = -1; first_v = -1; last_v = -1; word_n = 0; mism = 0;
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         case (cmd)
            4'b0011: begin act_n++; act_cyc = cyc; act_row = sd_addr; act_ba = sd_ba; end
            4'b0101: begin rd_n++; rd_cyc = cyc; rd_addr = sd_addr; rd_ba = sd_ba; end
            4'b0110: begin bt_n++; bt_cyc = cyc; end
            4'b0111: ;
            default: other_n++;
         endcase
         if (!busy && cmd != 4'b0111) idle_bad++;
         if (busy && !sd_cke) cke_bad++;
         if (busy && sd_dqm != 2'b00) dqm_bad++;
         if (rd_valid) begin
            if (word_n == 0) first_v = cyc;
            last_v = cyc;
            if (rd_data !== word_of(t_bank, t_row, 9'((int'(t_col) + word_n) % PAGE))) mism++;
            word_n++;
         end
         if (done) begin done_n++; done_cyc = cyc; end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_done();
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk); #1;
         if (done_n > 0) break;
      end
      repeat (4) @(negedge clk);
      #1;
   endtask

   // one burst; optionally inject a start while busy
   task automatic run_read(input logic [1:0] b, input logic [12:0] r,
                           input logic [8:0] c, input int n, input bit inject);
      int s;
      clear_mon();
      t_bank = b; t_row = r; t_col = c;
      @(negedge clk); #1;
      s = cyc;
      req_start = 1'b1; req_bank = b; req_row = r; req_col = c; req_len = 10'(n);
      @(negedge clk); #1;
      req_start = 1'b0;
      if (inject) begin
         repeat (3) @(negedge clk);
         #1;
         req_start = 1'b1; req_bank = ~b; req_row = r + 13'd7; req_col = c + 9'd3; req_len = 10'd7;
         @(negedge clk); #1;
         req_start = 1'b0;
      end
      wait_done();
      chk(act_cyc == s + 1, "R1 ACTIVE cycle", act_cyc - s, 1);
      chk(act_row == r && act_ba == b, "R1 row/bank", int'(act_row), int'(r));
      chk(rd_cyc - act_cyc == RCD && rd_ba == b, "R2 READ gap", rd_cyc - act_cyc, RCD);
      chk(rd_addr[10] == 1'b0, "R2 A10 low", int'(rd_addr[10]), 0);
      chk(rd_addr[8:0] == c && rd_addr[12:9] == 4'd0, "R3 column pins", int'(rd_addr), int'(c));
      chk(bt_cyc - rd_cyc == n && bt_n == 1, "R4 terminate slot", bt_cyc - rd_cyc, n);
      chk(word_n == n, "R5 word count", word_n, n);
      chk(mism == 0, "R5 word order", mism, 0);
      chk(first_v - rd_cyc == CL + 1, "R5 first valid", first_v - rd_cyc, CL + 1);
      chk(last_v - bt_cyc == CL, "R6 tail words", last_v - bt_cyc, CL);
      chk(other_n == 0 && idle_bad == 0, "R7 legal commands", other_n + idle_bad, 0);
      chk(done_n == 1 && done_cyc - bt_cyc == CL + 1 && !busy, "R10 done pulse",
          done_cyc - bt_cyc, CL + 1);
      chk(cke_bad == 0 && dqm_bad == 0, "R11 cke/dqm busy", cke_bad + dqm_bad, 0);
      if (inject) chk(act_n == 1, "R8 start while busy", act_n, 1);
   endtask

   task automatic test_reset();
      chk(!busy && !done && !rd_valid, "R11 reset idle", int'(busy), 0);
      chk(cmd == 4'b0111, "R11 reset NOP", int'(cmd), 7);
      chk(sd_cke == 1'b1 && sd_dqm == 2'b11, "R11 cke/dqm idle", int'(sd_dqm), 3);
   endtask

   task automatic test_zero_len();
      clear_mon();
      @(negedge clk); #1;
      req_start = 1'b1; req_len = 10'd0; req_bank = 2'd2; req_row = 13'd5; req_col = 9'd0;
      @(negedge clk); #1;
      req_start = 1'b0;
      repeat (8) @(negedge clk);
      #1;
      chk(act_n == 0 && !busy, "R9 zero length", act_n, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      #1 rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      test_reset();
      run_read(2'd1, 13'd300, 9'd16, 5, 1'b0);
      run_read(2'd0, 13'd1, 9'd0, 1, 1'b0);
      run_read(2'd3, 13'd8191, 9'd100, CL, 1'b0);
      run_read(2'd2, 13'd42, 9'd505, 12, 1'b1);   // wraps at page end
      run_read(2'd1, 13'd77, 9'd0, PAGE, 1'b0);   // whole page
      run_read(2'd0, 13'd9, 9'd400, 1000, 1'b0);  // wraps past start
      test_zero_len();
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000 && !finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule